// File: doc/BRIEF.md
# General-purpose I/O bank with per-pin interrupt detection

This block is one bank of sixteen general-purpose pins behind a small memory-mapped register file. Software makes each pin an input or an output, drives the output data and reads back pad values. Each pin can also be armed to detect a rising edge, a falling edge, either edge, a high level or a low level. The detected conditions appear as raw and enabled (masked) status words. A single interrupt line is the OR of the enabled status bits.

Pad inputs cross into the clock domain through a two-flop synchroniser. A per-pin input-enable gate decides whether a pad value is seen at all. A per-pin data mask decides which data bits a read or a write may touch. Edge events are latched until software acknowledges them by writing ones to the clear register. Level events are never latched and follow the synchronised pad directly. Reads are combinational from the address. Writes take effect on the clock edge that samples the write strobe.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every writable register is 0, all data reads return 0, `pad_oe` is 0, `pad_out` is 0 and `irq` is 0.
- R2: `pad_oe` bit i equals the direction bit i (1 = output, 0 = input), and `pad_out` carries the stored data bits.
- R3: A data read returns 0 for pins whose mask bit is 0. Output pins return the stored data bit. Input pins return the pad value after two-flop synchronisation, ANDed with the input-enable bit.
- R4: With sense 0 (edge), a both-edges bit of 1 flags any transition regardless of polarity. With both-edges 0, polarity 1 flags rising edges and polarity 0 flags falling edges. Only input-enabled pad values take part.
- R5: A flagged edge stays set in the raw status after the pad returns to its earlier value, until it is cleared.
- R6: Writing 1 to a bit of the clear register clears that pin's latched edge. Bits written as 0 leave it unchanged. The clear register reads as 0. An edge detected in the same cycle as a clear stays set.
- R7: With sense 1 (level), the raw status bit is 1 while the pin is input-enabled and its synchronised pad equals the polarity bit. It drops as soon as that stops holding.
- R8: Writes to the data register change only bits whose mask bit is 1.
- R9: The masked status equals raw status AND interrupt enable, and `irq` is 1 exactly when any masked status bit is 1.
- R10: Writes to the raw and masked status registers are ignored, and unmapped offsets read 0.
- R11: Byte offsets are: data 0x00, data mask 0x04, direction 0x08, sense 0x0C, both-edges 0x10, polarity 0x14, interrupt enable 0x18, raw status 0x1C, masked status 0x20, clear 0x24, input enable 0x28. Pin i is bit i of each register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pad_in | input | NPIN | Asynchronous pad inputs |
| pad_out | output | NPIN | Pad output data |
| pad_oe | output | NPIN | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench steps every sense, both-edges and polarity combination through transitions and steady pads. A design that let polarity matter in both-edges mode, or that latched level status, would then show the wrong raw word. It checks that an edge survives the pad returning, so a status that merely tracks the pad is caught. Zero bits in a clear write must spare the other pins, or the partial-clear result goes wrong. It also checks that masked data bits survive writes and read as 0. Inputs that are not enabled must stay invisible to both data reads and level detection. Writes to the read-only status words must leave them unchanged, or a later readback differs.

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DMSK = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_SNS  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_INEN = ADDR_W'('h28);

  logic [NPIN-1:0] dat_q, dmsk_q, dir_q, sns_q, both_q, pol_q, ien_q, inen_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q, edge_q;
  logic [NPIN-1:0] wd, in_v, rise, fall, edge_hit, lvl, raw, mis, clr_mask;
  logic            unused_wd;

  assign wd        = reg_wdata[NPIN-1:0];
  assign unused_wd = ^reg_wdata;

  assign in_v     = sync2_q & inen_q;
  assign rise     = in_v & ~prev_q;
  assign fall     = ~in_v & prev_q;
  assign edge_hit = ~sns_q & ((both_q & (rise | fall)) | (~both_q & pol_q & rise) | (~both_q & ~pol_q & fall));
  assign lvl      = inen_q & ~(sync2_q ^ pol_q);
  assign raw      = (sns_q & lvl) | (~sns_q & edge_q);
  assign mis      = raw & ien_q;
  assign clr_mask = (reg_wr && reg_addr == A_CLR) ? wd : '0;

  assign pad_out = dat_q;
  assign pad_oe  = dir_q;
  assign irq     = |mis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      dmsk_q <= '0;
      dir_q  <= '0;
      sns_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      inen_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DATA: dat_q  <= (dat_q & ~dmsk_q) | (wd & dmsk_q);
        A_DMSK: dmsk_q <= wd;
        A_DIR:  dir_q  <= wd;
        A_SNS:  sns_q  <= wd;
        A_BOTH: both_q <= wd;
        A_POL:  pol_q  <= wd;
        A_IEN:  ien_q  <= wd;
        A_INEN: inen_q <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      edge_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= in_v;
      edge_q  <= (edge_q & ~clr_mask) | edge_hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA: reg_rdata = 32'(dmsk_q & ((dir_q & dat_q) | (~dir_q & in_v)));
      A_DMSK: reg_rdata = 32'(dmsk_q);
      A_DIR:  reg_rdata = 32'(dir_q);
      A_SNS:  reg_rdata = 32'(sns_q);
      A_BOTH: reg_rdata = 32'(both_q);
      A_POL:  reg_rdata = 32'(pol_q);
      A_IEN:  reg_rdata = 32'(ien_q);
      A_RAW:  reg_rdata = 32'(raw);
      A_MSK:  reg_rdata = 32'(mis);
      A_INEN: reg_rdata = 32'(inen_q);
      default: reg_rdata = '0;
    endcase
  end

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_q) & ~edge_q & ~$past(clr_mask)) == '0); // R5

  AST_CLR_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR) |=> (edge_q & $past(wd) & ~$past(edge_hit)) == '0); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0)); // R9

  AST_MASKED_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DATA) |=> ((dat_q ^ $past(dat_q)) & ~$past(dmsk_q)) == '0); // R8

  AST_OE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_DIR) |=> $stable(pad_oe)); // R2

endmodule

// File: tb/tb_gpio_bank_irq.sv
`timescale 1ns/1ps
module tb_gpio_bank_irq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [15:0] pad_in = 0;
  logic [15:0] pad_out, pad_oe;
  logic        irq;
  int errors = 0;
  int checks = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  gpio_bank_irq #(.NPIN(16), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // fields: sense, both, polarity, pad before, pad after, expected raw
  localparam logic [5:0] VEC [12] = '{
    6'b001011, 6'b001100, 6'b000101, 6'b000010,
    6'b010011, 6'b011101, 6'b001110, 6'b101011,
    6'b101100, 6'b100101, 6'b100010, 6'b111011 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R11 offsets
    for (int i = 0; i <= 10; i++) begin
      rd(8'(i * 4), v);
      chk("R1", v, 32'h0);
    end
    chk("R1", {16'h0, pad_oe}, 32'h0);
    chk("R1", {16'h0, pad_out}, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);

    wr(8'h28, 32'hFFFF);
    for (int k = 0; k < 12; k++) begin
      pad_in = VEC[k][2] ? 16'hFFFF : 16'h0;
      settle();
      wr(8'h0C, VEC[k][5] ? 32'hFFFF : 32'h0);
      wr(8'h10, VEC[k][4] ? 32'hFFFF : 32'h0);
      wr(8'h14, VEC[k][3] ? 32'hFFFF : 32'h0);
      wr(8'h24, 32'hFFFF);
      pad_in = VEC[k][1] ? 16'hFFFF : 16'h0;
      settle();
      rd(8'h1C, v);
      chk(VEC[k][5] ? "R7 level" : "R4 edge", v, VEC[k][0] ? 32'hFFFF : 32'h0);
    end

    // R5 sticky edge, R6 clear
    wr(8'h0C, 0); wr(8'h10, 0); wr(8'h14, 32'hFFFF);
    pad_in = 0; settle(); wr(8'h24, 32'hFFFF);
    pad_in = 16'hFFFF; settle(); pad_in = 0; settle();
    rd(8'h1C, v); chk("R5", v, 32'hFFFF);
    wr(8'h24, 32'h0);
    rd(8'h1C, v); chk("R6 zero write", v, 32'hFFFF);
    rd(8'h24, v); chk("R6 clear reads 0", v, 32'h0);
    wr(8'h24, 32'h00FF);
    rd(8'h1C, v); chk("R6 partial", v, 32'hFF00);

    // R9 masked status and irq
    wr(8'h18, 32'h0F0F);
    rd(8'h20, v); chk("R9 masked", v, 32'h0F00);
    chk("R9 irq", {31'h0, irq}, 32'h1);
    wr(8'h18, 32'h00F0);
    rd(8'h20, v); chk("R9 masked", v, 32'h0);
    chk("R9 irq", {31'h0, irq}, 32'h0);

    // R10 read-only and unmapped
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); chk("R10 raw write", v, 32'hFF00);
    wr(8'h20, 32'hFFFF);
    rd(8'h20, v); chk("R10 masked write", v, 32'h0);
    rd(8'h2C, v); chk("R10 unmapped", v, 32'h0);

    // R7 input enable gates level
    wr(8'h28, 0); wr(8'h0C, 32'hFFFF); wr(8'h14, 0);
    pad_in = 0; settle();
    rd(8'h1C, v); chk("R7 inen off", v, 32'h0);
    wr(8'h28, 32'hFFFF);
    rd(8'h1C, v); chk("R7 inen on", v, 32'hFFFF);

    // R2 R3 R8 data path
    wr(8'h28, 32'h00F0); wr(8'h04, 32'h00FF); wr(8'h08, 32'h000F);
    wr(8'h00, 32'hFFFF);
    pad_in = 16'hF0F0; settle();
    rd(8'h00, v); chk("R3 read", v, 32'h00FF);
    chk("R8 masked write", {16'h0, pad_out}, 32'h00FF);
    chk("R2 oe", {16'h0, pad_oe}, 32'h000F);
    rd(8'h08, v); chk("R11 dir offset", v, 32'h000F);
    wr(8'h28, 32'h0030);
    rd(8'h00, v); chk("R3 inen", v, 32'h003F);
    wr(8'h04, 0);
    rd(8'h00, v); chk("R3 mask read", v, 32'h0);
    wr(8'h00, 32'h0);
    chk("R8 ignored", {16'h0, pad_out}, 32'h00FF);
    wr(8'h04, 32'hFFFF); wr(8'h00, 32'h0);
    chk("R8 write", {16'h0, pad_out}, 32'h0);

    finish_run();
  end
endmodule